// File: doc/BRIEF.md
# Vector Priority Interrupt Acceptance Unit

This unit sits beside one processor core and decides which interrupt, if any, the core should take next. Each interrupt is known only by an 8-bit vector. The upper four bits of the vector are its priority class. Requests arrive as single-cycle vector messages and set a bit in a 256-entry pending set. The unit offers the highest pending vector to the core whenever that vector's class beats the current processor priority. An acknowledge from the core moves the vector into a 256-entry in-service set. An end-of-interrupt retires the highest in-service vector.

The processor priority is the larger of a software-written task priority and the class of the highest vector in service. It is published on a port so that an external router can compare processors and steer new work to the least busy one. Software can switch delivery off and poll the pending set, one class of sixteen vectors at a time. An acknowledge with nothing deliverable returns a programmable spurious vector. Requests on the reserved vectors 0 to 15 raise a sticky error flag instead of becoming pending.

Top module: `vprio_accept`

## Requirements
- R1: The class of a vector is bits [7:4]. `int_req_o` is high exactly when delivery is enabled, some vector is pending, and the class of the highest pending vector is strictly greater than the class of `ppr_o`. `int_vec_o` then carries that highest pending vector.
- R2: An acknowledge while `int_req_o` is high clears that vector from pending and sets it in service. In the next cycle `ack_valid_o` is high and `ack_vec_o` holds the vector.
- R3: With nothing in service, `ppr_o` equals the task priority. Otherwise `ppr_o` equals the task priority when its class is at least the top in-service class. If not, `ppr_o` is that class in bits [7:4] with zeros in bits [3:0].
- R4: While a vector is in service, pending vectors whose class is equal to or lower than its class are held back. A pending vector of a higher class is offered and can be acknowledged on top of it.
- R5: A task priority write takes effect in the next cycle. Pending vectors whose class is not above the task priority class are then withheld.
- R6: An end-of-interrupt clears only the highest in-service vector, and `ppr_o` is recomputed from what remains. With nothing in service it has no effect.
- R7: A request on vectors 0 to 15 sets `err_o`, which stays set until reset, and leaves the pending set unchanged.
- R8: With delivery disabled, `int_req_o` stays low and requests still become pending. `poll_word_o` bit i shows whether vector {`poll_sel_i`, i} is pending.
- R9: An acknowledge while `int_req_o` is low returns the programmed spurious vector on `ack_vec_o` in the next cycle, with `ack_valid_o` high. It changes neither the pending set nor the in-service set.
- R10: After reset the pending and in-service sets are empty and the task priority is 0. Delivery is enabled, the spurious vector is 0xFF, `err_o` is 0 and `int_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Incoming interrupt message strobe |
| req_vec_i | input | 8 | Vector of the incoming message |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_i | input | 8 | Task priority value |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_deliver_i | input | 1 | Delivery enable (0 selects polled mode) |
| cfg_spur_i | input | 8 | Spurious vector value |
| ack_i | input | 1 | Core acknowledge |
| eoi_i | input | 1 | End-of-interrupt |
| poll_sel_i | input | 4 | Class selected for polling |
| int_req_o | output | 1 | Interrupt offered to the core |
| int_vec_o | output | 8 | Offered vector |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_vec_o | output | 8 | Vector returned for the acknowledge |
| ppr_o | output | 8 | Current processor priority |
| err_o | output | 1 | Sticky reserved-vector error |
| poll_word_o | output | 16 | Pending bits of the selected class |

## Verification
A request, task priority write or configuration write changes the outputs one clock edge after it is sampled. `ppr_o`, `int_req_o` and `int_vec_o` follow the registered sets combinationally, so they settle right after the edge that takes an acknowledge or end-of-interrupt. `ack_vec_o` and `ack_valid_o` hold for the single cycle after the acknowledge edge. The bench changes inputs on the falling edge and reads every result on the following falling edge, exactly one rising edge later. It sweeps every non-reserved vector through request, acknowledge and retire, and it crosses all sixteen task priority classes with every vector class.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam int VEC_W  = 8;
  localparam int CLS_W  = 4;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int SUB_W  = VEC_W - CLS_W;
  localparam int GRP_SZ = 1 << SUB_W;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_of(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Processor priority: task priority or the in-service class, whichever is higher
  function automatic vec_t ppr_of(input vec_t tpr, input logic isr_any, input vec_t isr_top);
    if (!isr_any || (cls_of(tpr) >= cls_of(isr_top)))
      return tpr;
    return {cls_of(isr_top), {SUB_W{1'b0}}};
  endfunction

  function automatic logic beats(input vec_t v, input vec_t ppr);
    return cls_of(v) > cls_of(ppr);
  endfunction

  function automatic logic is_reserved(input vec_t v);
    return cls_of(v) == '0;
  endfunction
endpackage

// File: rtl/iau_bitreg.sv
module iau_bitreg #(
  parameter int IDX_W = 8,
  localparam int N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     bits_q
);
  // A set and a clear of the same bit in one cycle leave it set
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        bits_q[i] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(i)))
        bits_q[i] <= 1'b1;
      else if (clr_en && (clr_idx == IDX_W'(i)))
        bits_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/iau_msb_find.sv
module iau_msb_find #(
  parameter int IDX_W = 8,
  parameter int GRP_W = 4,
  localparam int N    = 1 << IDX_W,
  localparam int HI_W = IDX_W - GRP_W,
  localparam int NGRP = 1 << HI_W,
  localparam int GSZ  = 1 << GRP_W
) (
  input  logic [N-1:0]     bits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NGRP-1:0] grp_any;
  logic [HI_W-1:0] top_grp;
  logic [GSZ-1:0]  grp_bits;
  logic [GRP_W-1:0] top_bit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |bits_i[g*GSZ +: GSZ];
  end

  // Two levels: highest non-empty group, then highest bit inside it
  always_comb begin
    top_grp = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp_any[g]) top_grp = HI_W'(g);
  end

  assign grp_bits = bits_i[top_grp*GSZ +: GSZ];

  always_comb begin
    top_bit = '0;
    for (int b = 0; b < GSZ; b++)
      if (grp_bits[b]) top_bit = GRP_W'(b);
  end

  assign any_o = |grp_any;
  assign idx_o = {top_grp, top_bit};
endmodule

// File: rtl/vprio_accept.sv
module vprio_accept
  import iau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             tpr_wr_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_deliver_i,
  input  logic [VEC_W-1:0] cfg_spur_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic [CLS_W-1:0] poll_sel_i,
  output logic             int_req_o,
  output logic [VEC_W-1:0] int_vec_o,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             err_o,
  output logic [GRP_SZ-1:0] poll_word_o
);
  localparam vec_t SPUR_RST = '1;

  // Registered state
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] isr_q;
  vec_t tpr_q;
  vec_t spur_q;
  logic en_q;
  logic err_q;
  logic ack_valid_q;
  vec_t ack_vec_q;

  // Named internal events
  logic pend_any, isr_any;
  vec_t pend_top, isr_top;
  vec_t ppr_w;
  logic deliver_w;
  logic take_w;
  logic spur_take_w;
  logic eoi_take_w;
  logic rsvd_req_w;
  logic pend_set_w;

  iau_msb_find #(.IDX_W(VEC_W), .GRP_W(SUB_W)) u_pend_find (
    .bits_i (pend_q),
    .any_o  (pend_any),
    .idx_o  (pend_top)
  );

  iau_msb_find #(.IDX_W(VEC_W), .GRP_W(SUB_W)) u_isr_find (
    .bits_i (isr_q),
    .any_o  (isr_any),
    .idx_o  (isr_top)
  );

  assign ppr_w       = ppr_of(tpr_q, isr_any, isr_top);
  assign deliver_w   = en_q && pend_any && beats(pend_top, ppr_w);
  assign take_w      = ack_i && deliver_w;
  assign spur_take_w = ack_i && !deliver_w;
  assign eoi_take_w  = eoi_i && isr_any;
  assign rsvd_req_w  = req_valid_i && is_reserved(req_vec_i);
  assign pend_set_w  = req_valid_i && !is_reserved(req_vec_i);

  iau_bitreg #(.IDX_W(VEC_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (pend_set_w),
    .set_idx (req_vec_i),
    .clr_en  (take_w),
    .clr_idx (pend_top),
    .bits_q  (pend_q)
  );

  // The acknowledged vector always outranks the retiring one, so set and clear never collide
  iau_bitreg #(.IDX_W(VEC_W)) u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (take_w),
    .set_idx (pend_top),
    .clr_en  (eoi_take_w),
    .clr_idx (isr_top),
    .bits_q  (isr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q       <= '0;
      spur_q      <= SPUR_RST;
      en_q        <= 1'b1;
      err_q       <= 1'b0;
      ack_valid_q <= 1'b0;
      ack_vec_q   <= '0;
    end else begin
      if (tpr_wr_i) tpr_q <= tpr_i;
      if (cfg_wr_i) begin
        en_q   <= cfg_deliver_i;
        spur_q <= cfg_spur_i;
      end
      if (rsvd_req_w) err_q <= 1'b1;
      ack_valid_q <= ack_i;
      if (ack_i) ack_vec_q <= take_w ? pend_top : spur_q;
    end
  end

  assign int_req_o   = deliver_w;
  assign int_vec_o   = pend_top;
  assign ack_valid_o = ack_valid_q;
  assign ack_vec_o   = ack_vec_q;
  assign ppr_o       = ppr_w;
  assign err_o       = err_q;
  assign poll_word_o = pend_q[poll_sel_i*GRP_SZ +: GRP_SZ];
endmodule

// File: rtl/iau_checker.sv
module iau_checker
  import iau_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_i,
  input logic [VEC_W-1:0]   req_vec_i,
  input logic               eoi_i,
  input logic               int_req_o,
  input logic [VEC_W-1:0]   int_vec_o,
  input logic               ack_valid_o,
  input logic [VEC_W-1:0]   ack_vec_o,
  input logic [VEC_W-1:0]   ppr_o,
  input logic               err_o,
  input logic               take_w,
  input logic               spur_take_w,
  input logic               eoi_take_w,
  input logic [NUM_VEC-1:0] isr_q,
  input logic               isr_any,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [VEC_W-1:0]   tpr_q,
  input logic [VEC_W-1:0]   spur_q,
  input logic               en_q
);
  assert_offer_beats_ppr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o |-> (int_vec_o[7:4] > ppr_o[7:4]));

  assert_ack_moves_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (ack_valid_o && (ack_vec_o == $past(int_vec_o)) && isr_q[$past(int_vec_o)]));

  assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_o >= tpr_q);

  assert_ppr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_any |-> (ppr_o == tpr_q));

  assert_eoi_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_take_w && !take_w) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (req_vec_i[7:4] == 4'h0)) |=> (err_o && !pend_q[$past(req_vec_i)]));

  assert_polled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !int_req_o);

  assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_take_w && !eoi_i) |=> ((ack_vec_o == $past(spur_q)) && (isr_q == $past(isr_q))));
endmodule

bind vprio_accept iau_checker u_iau_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_vec_i   (req_vec_i),
  .eoi_i       (eoi_i),
  .int_req_o   (int_req_o),
  .int_vec_o   (int_vec_o),
  .ack_valid_o (ack_valid_o),
  .ack_vec_o   (ack_vec_o),
  .ppr_o       (ppr_o),
  .err_o       (err_o),
  .take_w      (take_w),
  .spur_take_w (spur_take_w),
  .eoi_take_w  (eoi_take_w),
  .isr_q       (isr_q),
  .isr_any     (isr_any),
  .pend_q      (pend_q),
  .tpr_q       (tpr_q),
  .spur_q      (spur_q),
  .en_q        (en_q)
);

// File: tb/test_vprio_accept.sv
`timescale 1ns/1ps
module test_vprio_accept;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 1'b0;
  logic [7:0] req_vec_i = '0;
  logic tpr_wr_i = 1'b0;
  logic [7:0] tpr_i = '0;
  logic cfg_wr_i = 1'b0;
  logic cfg_deliver_i = 1'b1;
  logic [7:0] cfg_spur_i = '0;
  logic ack_i = 1'b0;
  logic eoi_i = 1'b0;
  logic [3:0] poll_sel_i = '0;
  logic int_req_o;
  logic [7:0] int_vec_o;
  logic ack_valid_o;
  logic [7:0] ack_vec_o;
  logic [7:0] ppr_o;
  logic err_o;
  logic [15:0] poll_word_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vprio_accept i_vprio_accept (.*);

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int v);
    req_valid_i = 1'b1; req_vec_i = 8'(v);
    cyc();
    req_valid_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1; cyc(); eoi_i = 1'b0;
  endtask

  task automatic set_tpr(input int t);
    tpr_wr_i = 1'b1; tpr_i = 8'(t); cyc(); tpr_wr_i = 1'b0;
  endtask

  task automatic set_cfg(input bit en, input int spur);
    cfg_wr_i = 1'b1; cfg_deliver_i = en; cfg_spur_i = 8'(spur);
    cyc(); cfg_wr_i = 1'b0;
  endtask

  // Expected processor priority computed arithmetically
  function automatic int exp_ppr(input int tpr, input int top_vec, input bit busy);
    if (!busy || (tpr / 16) >= (top_vec / 16)) return tpr;
    return (top_vec / 16) * 16;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();

    // R10 reset state
    chk("R10 int_req after reset", int'(int_req_o), 0);
    chk("R10 ppr after reset", int'(ppr_o), 0);
    chk("R10 err after reset", int'(err_o), 0);
    chk("R10 ack_valid after reset", int'(ack_valid_o), 0);
    poll_sel_i = 4'h5;
    #1 chk("R10 pending empty", int'(poll_word_o), 0);
    do_ack();
    chk("R10 default spurious vector", int'(ack_vec_o), 8'hFF);
    chk("R10 ack_valid on spurious", int'(ack_valid_o), 1);

    // R1 R2 R6 sweep over every non-reserved vector
    for (int v = 16; v < 256; v++) begin
      do_req(v);
      chk("R1 offered", int'(int_req_o), 1);
      chk("R1 offered vector", int'(int_vec_o), v);
      do_ack();
      chk("R2 ack valid", int'(ack_valid_o), 1);
      chk("R2 ack vector", int'(ack_vec_o), v);
      chk("R3 ppr in service", int'(ppr_o), exp_ppr(0, v, 1'b1));
      chk("R2 pending cleared", int'(int_req_o), 0);
      do_eoi();
      chk("R6 ppr after eoi", int'(ppr_o), 0);
      chk("R2 ack_valid one cycle", int'(ack_valid_o), 0);
    end

    // R5 task priority crossed with every class
    for (int t = 0; t < 16; t++) begin
      for (int c = 1; c < 16; c++) begin
        set_tpr(t * 16 + 3);
        do_req(c * 16 + 5);
        chk("R5 withheld by task priority", int'(int_req_o), (c > t) ? 1 : 0);
        chk("R3 ppr equals task priority", int'(ppr_o), t * 16 + 3);
        set_tpr(0);
        chk("R5 released", int'(int_vec_o), c * 16 + 5);
        do_ack();
        chk("R2 ack after release", int'(ack_vec_o), c * 16 + 5);
        do_eoi();
      end
    end

    // R4 nesting and preemption
    do_req(8'h45); do_ack();
    chk("R3 nested ppr", int'(ppr_o), 8'h40);
    do_req(8'h47);
    chk("R4 same class held", int'(int_req_o), 0);
    do_req(8'h30);
    chk("R4 lower class held", int'(int_req_o), 0);
    do_req(8'h52);
    chk("R4 higher class offered", int'(int_req_o), 1);
    chk("R4 higher vector", int'(int_vec_o), 8'h52);
    do_ack();
    chk("R4 preempting ack", int'(ack_vec_o), 8'h52);
    chk("R3 ppr raised", int'(ppr_o), 8'h50);
    set_tpr(8'h62);
    chk("R3 task priority wins", int'(ppr_o), 8'h62);
    set_tpr(0);
    do_eoi();
    chk("R6 ppr falls to next in service", int'(ppr_o), 8'h40);
    chk("R4 still held", int'(int_req_o), 0);
    set_tpr(8'h32);
    chk("R3 in-service class wins", int'(ppr_o), 8'h40);
    set_tpr(8'h4A);
    chk("R3 equal class keeps task priority", int'(ppr_o), 8'h4A);
    set_tpr(0);
    do_eoi();
    chk("R6 ppr empty", int'(ppr_o), 0);
    chk("R1 next offered", int'(int_vec_o), 8'h47);
    do_ack(); do_eoi();
    chk("R1 lowest offered last", int'(int_vec_o), 8'h30);
    do_ack(); do_eoi();
    chk("R1 all drained", int'(int_req_o), 0);
    do_eoi();
    chk("R6 eoi with nothing in service", int'(ppr_o), 0);

    // R7 reserved vectors
    do_req(8'h05);
    chk("R7 error flag", int'(err_o), 1);
    chk("R7 not offered", int'(int_req_o), 0);
    poll_sel_i = 4'h0;
    #1 chk("R7 not pending", int'(poll_word_o), 0);
    cyc();
    chk("R7 flag sticky", int'(err_o), 1);

    // R9 spurious with only ineligible work pending
    set_cfg(1'b1, 8'hA7);
    set_tpr(8'hF0);
    do_req(8'h77);
    do_ack();
    chk("R9 spurious vector", int'(ack_vec_o), 8'hA7);
    chk("R9 in service untouched", int'(ppr_o), 8'hF0);
    poll_sel_i = 4'h7;
    #1 chk("R9 pending untouched", int'(poll_word_o), 16'h0080);
    set_tpr(0);
    do_ack();
    chk("R9 real vector after", int'(ack_vec_o), 8'h77);
    do_eoi();

    // R8 polled mode
    set_cfg(1'b0, 8'hA7);
    do_req(8'h83); do_req(8'h8A); do_req(8'h21);
    chk("R8 no delivery", int'(int_req_o), 0);
    poll_sel_i = 4'h8;
    #1 chk("R8 poll class 8", int'(poll_word_o), 16'h0408);
    poll_sel_i = 4'h2;
    #1 chk("R8 poll class 2", int'(poll_word_o), 16'h0002);
    do_ack();
    chk("R8 ack in polled mode is spurious", int'(ack_vec_o), 8'hA7);
    poll_sel_i = 4'h8;
    #1 chk("R8 pending kept", int'(poll_word_o), 16'h0408);
    set_cfg(1'b1, 8'hA7);
    chk("R8 delivery resumes", int'(int_vec_o), 8'h8A);
    do_ack();
    chk("R2 polled vector taken", int'(ack_vec_o), 8'h8A);
    #1 chk("R2 pending bit cleared", int'(poll_word_o), 16'h0008);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule